// File: doc/BRIEF.md
# Nibble-Serial Page-Load Receiver

This block sits on the device side of a four-bit, nibble-serial host bus and decodes one kind of transaction: a firmware-memory write frame that loads a whole page. Each frame begins with a start nibble, given while the active-low frame line is low. A device-select nibble comes next, then a seven-nibble address, a size nibble, and a stream of up to 128 data bytes. The receiver keeps only the page-row part of the address. It rebuilds each data byte from two nibbles and presents every byte with a one-cycle write strobe and its index within the page.

The data stream is flow-controlled. After every sixteenth byte the receiver pulls its ready line low for a programmable number of clocks, which models the transfer of an internal buffer. Nibbles are taken only while ready is high and the load-enable strobe is low. A frame that has the wrong start code, the wrong select value, or the mode pin low is dropped. A new frame start aborts any load in progress.

Top module: `pgload_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, `ready_o` is 1 and `wr_o`, `idx_o`, `byte_o` and `row_o` are all 0.
- R2: A frame is decoded only when the nibble sampled in the last clock with `frame_n` low equals 4'b1110. Earlier nibbles in the same low period have no effect, and any other final value makes the frame produce no writes.
- R3: The nibble in the first clock with `frame_n` high must equal `strap_id`, and `mode_i` must be 1 in that same clock. Otherwise the frame produces no writes.
- R4: The seven nibbles after the select nibble form a 28-bit address, sent most-significant nibble first. `row_o` takes address bits [20:7], with address bit 7 at `row_o[0]`. The other address bits have no effect, and `row_o` holds its value until the next decoded frame.
- R5: The single nibble after the address is skipped, and its value has no effect on the row or the data.
- R6: Data nibbles arrive least-significant first. When the second nibble of a byte is taken, the next cycle shows `wr_o`=1 for exactly one cycle, with `byte_o`={second, first} and `idx_o` counting up from 0 within the frame.
- R7: A nibble is taken only at a clock where `ready_o` is 1 and `ld_n` is 0. Nibbles offered at any other clock are ignored.
- R8: `ready_o` goes low in the same cycle as the strobe of each byte whose index is 15 modulo 16. It stays low for exactly `BUSY_CYC` cycles and then returns high.
- R9: After the byte with index 127 has been written, the receiver is idle. Later data nibbles produce no writes until a new frame is decoded.
- R10: `frame_n` low at any clock aborts the current load, including one partway through a byte. No strobe follows that clock, and the next decoded frame writes again from index 0 with correctly paired nibbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame marker |
| nib_i | input | 4 | Nibble bus |
| ld_n | input | 1 | Active-low data load enable |
| mode_i | input | 1 | Page-load mode select, 1 = decode |
| strap_id | input | 4 | Device select value set by straps |
| row_o | output | 14 | Page row, address bits [20:7] |
| idx_o | output | 7 | Byte index within the page |
| byte_o | output | 8 | Assembled data byte |
| wr_o | output | 1 | One-cycle byte write strobe |
| ready_o | output | 1 | High = ready for data, low = busy |

## Verification
Two situations are hard to reach: a host that keeps offering nibbles with the load strobe asserted while the receiver is busy, and a frame restart that arrives after only the low nibble of a byte. A well-behaved host never causes either. The bench therefore has a "pushy" host mode that drives fresh junk nibbles with `ld_n` low for every busy cycle. It also has an abort scenario that sends an odd number of nibbles before starting a new frame, then checks that the new frame's bytes are paired correctly from index 0.

// File: rtl/pgload_pkg.sv
package pgload_pkg;
  localparam int NIB_W = 4;
  localparam logic [NIB_W-1:0] FW_WRITE_CODE = 4'b1110;

  typedef enum logic [2:0] {
    HS_IDLE,
    HS_START,
    HS_ADDR,
    HS_SIZE,
    HS_DATA
  } hdr_st_e;
endpackage

// File: rtl/pgload_hdr.sv
module pgload_hdr
  import pgload_pkg::*;
#(
  parameter int ADDR_NIBS = 7,
  parameter int ROW_LO    = 7,
  parameter int ROW_HI    = 20,
  localparam int ROW_W    = ROW_HI - ROW_LO + 1,
  localparam int ADDR_W   = NIB_W * ADDR_NIBS,
  localparam int CNT_W    = $clog2(ADDR_NIBS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] nib,
  input  logic [NIB_W-1:0] strap_id,
  input  logic             mode_i,
  input  logic             page_done,
  output logic             data_act,
  output logic [ROW_W-1:0] row_q
);

  hdr_st_e          st;
  logic [NIB_W-1:0] start_q;
  logic [CNT_W-1:0] acnt;
  logic             addr_go;
  logic [ROW_W-1:0] row_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= HS_IDLE;
      start_q <= '0;
      acnt    <= '0;
    end else if (!frame_n) begin
      // every low clock overwrites: the final one wins
      st      <= HS_START;
      start_q <= nib;
      acnt    <= '0;
    end else begin
      unique case (st)
        HS_START: st <= (start_q == FW_WRITE_CODE && nib == strap_id && mode_i)
                        ? HS_ADDR : HS_IDLE;
        HS_ADDR: begin
          if (acnt == CNT_W'(ADDR_NIBS - 1)) begin
            st   <= HS_SIZE;
            acnt <= '0;
          end else begin
            acnt <= acnt + 1'b1;
          end
        end
        HS_SIZE: st <= HS_DATA;
        HS_DATA: if (page_done) st <= HS_IDLE;
        default: st <= HS_IDLE;
      endcase
    end
  end

  assign addr_go  = frame_n && (st == HS_ADDR);
  assign data_act = frame_n && (st == HS_DATA);

  // each row bit is loaded straight from the nibble slot that carries it
  for (genvar j = 0; j < ROW_W; j++) begin : g_row
    localparam int ABIT = ROW_LO + j;
    localparam int SLOT = (ADDR_W - 1 - ABIT) / NIB_W;
    localparam int POS  = ABIT % NIB_W;
    assign row_nx[j] = (addr_go && acnt == CNT_W'(SLOT)) ? nib[POS] : row_q[j];
  end

  always_ff @(posedge clk) begin
    if (rst) row_q <= '0;
    else     row_q <= row_nx;
  end

endmodule

// File: rtl/pgload_asm.sv
module pgload_asm
  import pgload_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int BLK_BYTES  = 16,
  localparam int IDX_W     = $clog2(PAGE_BYTES),
  localparam int BLK_W     = $clog2(BLK_BYTES),
  localparam int BYTE_W    = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  logic [NIB_W-1:0]  nib,
  output logic              wr_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              page_done,
  output logic              blk_fill
);

  logic             phase;
  logic [NIB_W-1:0] lo_q;
  logic [IDX_W-1:0] cnt;
  logic             hi_take;

  assign hi_take   = take && phase;
  assign page_done = hi_take && (cnt == IDX_W'(PAGE_BYTES - 1));
  assign blk_fill  = hi_take && (&cnt[BLK_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= 1'b0;
      lo_q   <= '0;
      cnt    <= '0;
      wr_o   <= 1'b0;
      idx_o  <= '0;
      byte_o <= '0;
    end else begin
      wr_o <= 1'b0;
      if (clr) begin
        phase <= 1'b0;
        cnt   <= '0;
      end else if (take) begin
        if (!phase) begin
          lo_q  <= nib;
          phase <= 1'b1;
        end else begin
          phase  <= 1'b0;
          wr_o   <= 1'b1;
          idx_o  <= cnt;
          byte_o <= {nib, lo_q};
          cnt    <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pgload_busy.sv
module pgload_busy #(
  parameter int BUSY_CYC = 8,
  localparam int CW      = $clog2(BUSY_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic ready_o
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_o <= 1'b1;
      cnt     <= '0;
    end else if (trig) begin
      ready_o <= 1'b0;
      cnt     <= CW'(BUSY_CYC);
    end else if (!ready_o) begin
      if (cnt == CW'(1)) ready_o <= 1'b1;
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/pgload_rx.sv
module pgload_rx
  import pgload_pkg::*;
#(
  parameter int ADDR_NIBS  = 7,
  parameter int ROW_LO     = 7,
  parameter int ROW_HI     = 20,
  parameter int PAGE_BYTES = 128,
  parameter int BLK_BYTES  = 16,
  parameter int BUSY_CYC   = 8,
  localparam int ROW_W     = ROW_HI - ROW_LO + 1,
  localparam int IDX_W     = $clog2(PAGE_BYTES),
  localparam int BLK_W     = $clog2(BLK_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic [3:0]       nib_i,
  input  logic             ld_n,
  input  logic             mode_i,
  input  logic [3:0]       strap_id,
  output logic [ROW_W-1:0] row_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [7:0]       byte_o,
  output logic             wr_o,
  output logic             ready_o
);

  logic data_act;
  logic page_done;
  logic blk_fill;
  logic take;

  assign take = data_act && ready_o && !ld_n;

  pgload_hdr #(
    .ADDR_NIBS(ADDR_NIBS),
    .ROW_LO   (ROW_LO),
    .ROW_HI   (ROW_HI)
  ) hdr_i (
    .clk      (clk),
    .rst      (rst),
    .frame_n  (frame_n),
    .nib      (nib_i),
    .strap_id (strap_id),
    .mode_i   (mode_i),
    .page_done(page_done),
    .data_act (data_act),
    .row_q    (row_o)
  );

  pgload_asm #(
    .PAGE_BYTES(PAGE_BYTES),
    .BLK_BYTES (BLK_BYTES)
  ) asm_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (!frame_n),
    .take     (take),
    .nib      (nib_i),
    .wr_o     (wr_o),
    .idx_o    (idx_o),
    .byte_o   (byte_o),
    .page_done(page_done),
    .blk_fill (blk_fill)
  );

  pgload_busy #(
    .BUSY_CYC(BUSY_CYC)
  ) busy_i (
    .clk    (clk),
    .rst    (rst),
    .trig   (blk_fill),
    .ready_o(ready_o)
  );

endmodule

// File: rtl/pgload_rx_chk.sv
module pgload_rx_chk #(
  parameter int IDX_W    = 7,
  parameter int BLK_W    = 4,
  parameter int BUSY_CYC = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_n,
  input logic             ready_o,
  input logic             wr_o,
  input logic [IDX_W-1:0] idx_o
);

  logic [31:0]      lowcnt;
  logic             have_prev;
  logic [IDX_W-1:0] prev_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      lowcnt    <= '0;
      have_prev <= 1'b0;
      prev_idx  <= '0;
    end else begin
      lowcnt <= ready_o ? '0 : lowcnt + 1;
      if (wr_o) begin
        have_prev <= 1'b1;
        prev_idx  <= idx_o;
      end
    end
  end

  a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_o |=> !wr_o);

  a_r6_idx_step: assert property (@(posedge clk) disable iff (rst)
    (wr_o && have_prev) |-> (idx_o == IDX_W'(prev_idx + 1'b1) || idx_o == '0));

  a_r8_fall_on_block: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_o) |-> (wr_o && (&idx_o[BLK_W-1:0])));

  a_r8_low_bound: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> (lowcnt < BUSY_CYC));

  a_r8_rise_len: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> (lowcnt == BUSY_CYC));

  a_r7_no_take_busy: assert property (@(posedge clk) disable iff (rst)
    !ready_o |=> !wr_o);

  a_r10_abort_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !frame_n |=> !wr_o);

endmodule

bind pgload_rx pgload_rx_chk #(
  .IDX_W   (IDX_W),
  .BLK_W   (BLK_W),
  .BUSY_CYC(BUSY_CYC)
) chk_i (
  .clk    (clk),
  .rst    (rst),
  .frame_n(frame_n),
  .ready_o(ready_o),
  .wr_o   (wr_o),
  .idx_o  (idx_o)
);

// File: tb/pgload_rx_tb_top.sv
module pgload_rx_tb_top;
  localparam int BUSY = 6;
  localparam logic [3:0] STRAP = 4'h9;

  logic        clk = 1'b0;
  logic        rst;
  logic        frame_n, ld_n, mode_i;
  logic [3:0]  nib_i, strap_id;
  logic [13:0] row_o;
  logic [6:0]  idx_o;
  logic [7:0]  byte_o;
  logic        wr_o, ready_o;

  pgload_rx #(.BUSY_CYC(BUSY)) dut_i (
    .clk(clk), .rst(rst), .frame_n(frame_n), .nib_i(nib_i), .ld_n(ld_n),
    .mode_i(mode_i), .strap_id(strap_id), .row_o(row_o), .idx_o(idx_o),
    .byte_o(byte_o), .wr_o(wr_o), .ready_o(ready_o)
  );

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // output monitor
  logic [7:0] got [128];
  int nwr, order_bad, falls, bad_falls, runs, bad_runs, lowrun, last_idx, exp_next;
  logic ready_prev = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_o) begin
        if (idx_o == 7'd0) exp_next = 0;
        if (int'(idx_o) != exp_next) order_bad++;
        got[idx_o] = byte_o;
        nwr++;
        last_idx = int'(idx_o);
        exp_next = int'(idx_o) + 1;
      end
      if (ready_prev && !ready_o) begin
        falls++;
        if (!(wr_o && idx_o[3:0] == 4'hF)) bad_falls++;
      end
      if (!ready_o) lowrun++;
      else if (lowrun > 0) begin
        runs++;
        if (lowrun != BUSY) bad_runs++;
        lowrun = 0;
      end
      ready_prev = ready_o;
    end
  end

  task automatic clear_mon();
    @(posedge clk); #1;
    nwr = 0; order_bad = 0; falls = 0; bad_falls = 0; runs = 0;
    bad_runs = 0; lowrun = 0; last_idx = -1; exp_next = 0;
    for (int i = 0; i < 128; i++) got[i] = 8'h00;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int b);
    return seed + 8'(b * 37);
  endfunction

  task automatic put(input logic fr, input logic [3:0] n, input logic ld);
    @(negedge clk);
    frame_n = fr; nib_i = n; ld_n = ld;
  endtask

  // starts: nibbles sent with frame low, entry 0 first, entry nst-1 last
  task automatic frame(input logic [11:0] starts, input int nst, input logic [3:0] id,
                       input logic [27:0] addr, input logic [3:0] sz);
    for (int i = 0; i < nst; i++) put(1'b0, starts[4*i +: 4], 1'b1);
    put(1'b1, id, 1'b1);
    for (int k = 0; k < 7; k++) put(1'b1, addr[27-4*k -: 4], 1'b1);
    put(1'b1, sz, 1'b1);
  endtask

  task automatic put_d(input logic [3:0] n, input bit gaps, input bit pushy);
    if (gaps) put(1'b1, 4'h5, 1'b1);
    @(negedge clk);
    while (!ready_o) begin
      frame_n = 1'b1;
      nib_i   = pushy ? 4'hC : n;
      ld_n    = pushy ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    frame_n = 1'b1; nib_i = n; ld_n = 1'b0;
  endtask

  task automatic data(input int nb, input logic [7:0] seed, input bit gaps, input bit pushy);
    for (int b = 0; b < nb; b++) begin
      put_d(pat(seed, b) & 8'h0F ? pat(seed, b)[3:0] : 4'h0, gaps, pushy);
      put_d(pat(seed, b)[7:4], gaps, pushy);
    end
  endtask

  task automatic settle();
    put(1'b1, 4'h0, 1'b1);
    repeat (BUSY + 4) @(negedge clk);
  endtask

  function automatic int mism(input int nb, input logic [7:0] seed);
    int m = 0;
    for (int b = 0; b < nb; b++) if (got[b] !== pat(seed, b)) m++;
    return m;
  endfunction

  task automatic t_reset();
    rst = 1'b1; frame_n = 1'b1; ld_n = 1'b1; mode_i = 1'b1; nib_i = 4'h0; strap_id = STRAP;
    repeat (3) @(negedge clk);
    chk(ready_o == 1'b1 && wr_o == 1'b0, "R1", "ready/wr in reset", {ready_o, wr_o}, 2);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(ready_o == 1'b1 && wr_o == 1'b0 && idx_o == 0 && byte_o == 0 && row_o == 0,
        "R1", "outputs after reset", int'(row_o), 0);
  endtask

  task automatic t_full_page();
    logic [27:0] a = 28'h5A3_C9E1;
    clear_mon();
    frame(12'h00E, 1, STRAP, a, 4'h3);
    data(128, 8'h11, 1'b0, 1'b0);
    settle();
    chk(nwr == 128, "R6", "write count full page", nwr, 128);
    chk(order_bad == 0, "R6", "index order errors", order_bad, 0);
    chk(mism(128, 8'h11) == 0, "R6", "byte mismatches", mism(128, 8'h11), 0);
    chk(row_o == a[20:7], "R4", "row", int'(row_o), int'(a[20:7]));
    chk(falls == 8 && bad_falls == 0, "R8", "busy falls at block ends", falls, 8);
    chk(runs == 8 && bad_runs == 0, "R8", "busy length runs ok", runs - bad_runs, 8);
    clear_mon();
    data(4, 8'h40, 1'b0, 1'b0);
    settle();
    chk(nwr == 0, "R9", "writes after page end", nwr, 0);
  endtask

  task automatic t_bad_start();
    clear_mon();
    frame(12'h00D, 1, STRAP, 28'h0001234, 4'h0);
    data(4, 8'h22, 1'b0, 1'b0);
    settle();
    chk(nwr == 0, "R2", "writes with bad start code", nwr, 0);
  endtask

  task automatic t_multi_start();
    clear_mon();
    frame(12'hE53, 3, STRAP, 28'h0000080, 4'h0);
    data(3, 8'h33, 1'b0, 1'b0);
    settle();
    chk(nwr == 3 && mism(3, 8'h33) == 0, "R2", "last start accepted", nwr, 3);
    clear_mon();
    frame(12'h7EE, 3, STRAP, 28'h0000080, 4'h0);
    data(3, 8'h34, 1'b0, 1'b0);
    settle();
    chk(nwr == 0, "R2", "earlier valid start not used", nwr, 0);
  endtask

  task automatic t_select();
    clear_mon();
    frame(12'h00E, 1, STRAP ^ 4'h1, 28'h0000100, 4'h0);
    data(3, 8'h44, 1'b0, 1'b0);
    settle();
    chk(nwr == 0, "R3", "writes with wrong select", nwr, 0);
    clear_mon();
    mode_i = 1'b0;
    frame(12'h00E, 1, STRAP, 28'h0000100, 4'h0);
    data(3, 8'h45, 1'b0, 1'b0);
    settle();
    mode_i = 1'b1;
    chk(nwr == 0, "R3", "writes with mode low", nwr, 0);
  endtask

  task automatic t_addr_dc();
    logic [13:0] r = 14'h2A5C;
    logic [27:0] a = {7'h7F, r, 7'h7F};
    clear_mon();
    frame(12'h00E, 1, STRAP, a, 4'hF);
    data(2, 8'h55, 1'b0, 1'b0);
    settle();
    chk(row_o == r, "R4", "row with other bits set", int'(row_o), int'(r));
    chk(nwr == 2 && mism(2, 8'h55) == 0, "R5", "size nibble F no effect", nwr, 2);
  endtask

  task automatic t_flow();
    clear_mon();
    frame(12'h00E, 1, STRAP, 28'h0000000, 4'h6);
    data(20, 8'h66, 1'b1, 1'b1);
    settle();
    chk(nwr == 20, "R7", "writes with gaps and busy pushing", nwr, 20);
    chk(mism(20, 8'h66) == 0, "R7", "bytes with ignored nibbles", mism(20, 8'h66), 0);
    chk(falls == 1 && runs == 1 && bad_runs == 0, "R8", "one busy window", runs, 1);
  endtask

  task automatic t_abort();
    logic [27:0] b = 28'h0123_F80;
    clear_mon();
    frame(12'h00E, 1, STRAP, 28'h0000000, 4'h0);
    data(5, 8'h77, 1'b0, 1'b0);
    put_d(4'hB, 1'b0, 1'b0);
    frame(12'h00E, 1, STRAP, b, 4'h0);
    data(3, 8'h88, 1'b0, 1'b0);
    settle();
    chk(nwr == 8, "R10", "total writes over abort", nwr, 8);
    chk(last_idx == 2, "R10", "restart index", last_idx, 2);
    chk(mism(3, 8'h88) == 0, "R10", "bytes after restart", mism(3, 8'h88), 0);
    chk(row_o == b[20:7], "R10", "row of new frame", int'(row_o), int'(b[20:7]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_full_page();
    t_bad_start();
    t_multi_start();
    t_select();
    t_addr_dc();
    t_flow();
    t_abort();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule